// File: doc/BRIEF.md
# Decoded-op line cache with sticky fetch mode

This block keeps already-decoded macro-operations so that a repeated code stream can be replayed without running the instruction-cache fetch and decode path again. Each cached line belongs to one 64-byte code region, addressed here by its region number. A line has a fixed number of op slots. A normal op fills one slot. An op that carries a 64-bit immediate fills two adjacent slots.

Each fetch request looks up its region. A hit on a usable line returns the whole line in one beat to the op queue. The block then runs in cache mode, and the decode front end's clock enable is dropped. A miss returns the block to decode mode and raises a one-cycle request for the decode path. The ops that the decoders produce for that region are then packed into a new line. A region whose ops need more slots than a line holds is stored as unusable, and that region is always served by the decode path. With two threads active, each thread is limited to its own half of the sets.

Top module: `oc_fetch_ctrl`

## Requirements
- R1: After reset: out_valid=0, oc_mode=0 (decode mode), ic_clk_en=1 and fetch_ready=1.
- R2: A fetch that misses is reported one cycle after acceptance. ic_fetch_valid pulses for one cycle with the region in ic_fetch_region, oc_mode becomes 0, ic_clk_en becomes 1, and out_valid stays 0.
- R3: After a miss, the decoded ops are packed from slot 0 upward. Slot k is out_slots[k*OPW +: OPW]. A narrow op (dec_wide=0) stores dec_op[OPW-1:0] in one slot. A wide op stores its low half in slot p and its high half in slot p+1. The op flagged dec_last closes the line.
- R4: A fetch that hits a usable line gives out_valid one cycle after acceptance. The line's slots and its used-slot count appear on out_count. In the same cycle oc_mode=1 and ic_clk_en=0.
- R5: The mode is sticky. It changes only when a fetch is accepted. Consecutive hits keep cache mode, and idle cycles keep the current mode.
- R6: A line may fill all 8 slots exactly. If a region's ops need more slots than that, the line is marked unusable, and every later fetch of that region is served as in R2.
- R7: While out_valid=1 and q_ready=0, the outputs hold their values and fetch_ready=0. No line is dropped.
- R8: Each set holds 8 ways and is filled in round-robin order. After 9 distinct regions map to one set, the first region misses and the other 8 still hit.
- R9: With smt_en=1 the set index is {fetch_tid, region[IW-2:0]}, so a line filled by thread 0 misses for thread 1 at the same region. With smt_en=0 the index is region[IW-1:0] and fetch_tid has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smt_en | input | 1 | Two threads active; partitions the sets |
| fetch_valid | input | 1 | Fetch request valid |
| fetch_tid | input | 1 | Thread of the fetch |
| fetch_region | input | AW | 64-byte region number of the fetch |
| fetch_ready | output | 1 | Fetch accepted this cycle when valid |
| dec_valid | input | 1 | Decoded op valid |
| dec_op | input | 2*OPW | Op word; upper half used only when wide |
| dec_wide | input | 1 | Op carries a wide immediate (two slots) |
| dec_last | input | 1 | Last op of the region |
| q_ready | input | 1 | Op queue can take a line |
| out_valid | output | 1 | Line delivered from the cache |
| out_slots | output | SLOTS*OPW | Slot contents of the line |
| out_count | output | clog2(SLOTS+1) | Used slots in the line |
| oc_mode | output | 1 | 1 = cache mode, 0 = decode mode |
| ic_clk_en | output | 1 | Clock enable for the decode front end |
| ic_fetch_valid | output | 1 | Region must be served by the decode path |
| ic_fetch_region | output | AW | Region for the decode path |

## Verification
A corrupted tag or valid bit shows up as a false hit or miss. It is visible one cycle after the fetch is accepted, either as a line delivered where a decode request was expected or the reverse, with oc_mode flipping the wrong way. Errors in slot packing or the overflow flag remain hidden until the region is fetched again, and then show up as wrong slot words, a wrong count, or a usable line that should have gone to the decode path. A wrong round-robin pointer or a wrong partition index only shows up as an unexpected miss or hit on a later fetch.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic {MODE_IC = 1'b0, MODE_OC = 1'b1} oc_mode_e;
endpackage

// File: rtl/oc_line_ram.sv
module oc_line_ram #(
  parameter int DW    = 132,
  parameter int DEPTH = 128,
  localparam int RAW  = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [RAW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic           re,
  input  logic [RAW-1:0] raddr,
  output logic [DW-1:0]  rdata
);
  logic [DW-1:0] mem [DEPTH];

  // read-first single clock RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/oc_tags.sv
module oc_tags #(
  parameter int AW   = 20,
  parameter int SETS = 16,
  parameter int WAYS = 8,
  localparam int IW  = $clog2(SETS),
  localparam int WB  = $clog2(WAYS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] lk_set,
  input  logic [AW-1:0] lk_tag,
  output logic          lk_hit,
  output logic          lk_usable,
  output logic [WB-1:0] lk_way,
  output logic [WB-1:0] lk_victim,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_set,
  input  logic [WB-1:0] wr_way,
  input  logic [AW-1:0] wr_tag,
  input  logic          wr_usable
);
  logic [AW-1:0]   tag_q [SETS][WAYS];
  logic [WAYS-1:0] vld_q [SETS];
  logic [WAYS-1:0] use_q [SETS];
  logic [WB-1:0]   rr_q  [SETS];
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
  end

  always_comb begin
    lk_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (match[w]) lk_way = WB'(w);
  end

  assign lk_hit    = |match;
  assign lk_usable = use_q[lk_set][lk_way];
  assign lk_victim = rr_q[lk_set];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        use_q[s] <= '0;
        rr_q[s]  <= '0;
      end
    end else if (wr_en) begin
      tag_q[wr_set][wr_way] <= wr_tag;
      vld_q[wr_set][wr_way] <= 1'b1;
      use_q[wr_set][wr_way] <= wr_usable;
      rr_q[wr_set]          <= rr_q[wr_set] + 1'b1;
    end
  end

  // R8: one region never sits in two ways of a set
  a_r8_single_match: assert property (@(posedge clk) disable iff (rst) $onehot0(match));
endmodule

// File: rtl/oc_fill.sv
module oc_fill #(
  parameter int AW    = 20,
  parameter int SETS  = 16,
  parameter int WAYS  = 8,
  parameter int SLOTS = 8,
  parameter int OPW   = 16,
  localparam int IW   = $clog2(SETS),
  localparam int WB   = $clog2(WAYS),
  localparam int SW   = $clog2(SLOTS),
  localparam int CW   = $clog2(SLOTS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [AW-1:0]        start_tag,
  input  logic [IW-1:0]        start_set,
  input  logic [WB-1:0]        start_way,
  input  logic                 dec_valid,
  input  logic [2*OPW-1:0]     dec_op,
  input  logic                 dec_wide,
  input  logic                 dec_last,
  output logic                 cm_en,
  output logic [AW-1:0]        cm_tag,
  output logic [IW-1:0]        cm_set,
  output logic [WB-1:0]        cm_way,
  output logic                 cm_usable,
  output logic [SLOTS*OPW-1:0] cm_line,
  output logic [CW-1:0]        cm_count
);
  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW:0]   N1   = (CW+1)'(1);
  localparam logic [CW:0]   N2   = (CW+1)'(2);
  localparam logic [CW:0]   CAP  = (CW+1)'(SLOTS);

  logic           active_q, ovf_q;
  logic [CW-1:0]  ptr_q;
  logic [OPW-1:0] slots_q [SLOTS];
  logic [CW:0]    need_sum;
  logic           fits;

  assign need_sum = {1'b0, ptr_q} + (dec_wide ? N2 : N1);
  assign fits     = need_sum <= CAP;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      ovf_q    <= 1'b0;
      ptr_q    <= '0;
      cm_en    <= 1'b0;
    end else begin
      cm_en <= 1'b0;
      if (start) begin
        active_q <= 1'b1;
        ovf_q    <= 1'b0;
        ptr_q    <= '0;
        cm_tag   <= start_tag;
        cm_set   <= start_set;
        cm_way   <= start_way;
      end else if (active_q && dec_valid) begin
        if (!ovf_q && fits) begin
          slots_q[SW'(ptr_q)] <= dec_op[OPW-1:0];
          if (dec_wide) slots_q[SW'(ptr_q + ONE)] <= dec_op[2*OPW-1:OPW];
          ptr_q <= need_sum[CW-1:0];
        end else begin
          ovf_q <= 1'b1;
        end
        if (dec_last) begin
          active_q <= 1'b0;
          cm_en    <= 1'b1;
        end
      end
    end
  end

  for (genvar k = 0; k < SLOTS; k++) begin : g_pack
    assign cm_line[k*OPW +: OPW] = slots_q[k];
  end
  assign cm_count  = ptr_q;
  assign cm_usable = !ovf_q;

  // R3: slot pointer never passes the line capacity
  a_r3_ptr_bound: assert property (@(posedge clk) disable iff (rst) ptr_q <= CW'(SLOTS));
  // R6: an overflowing fill stays marked until it closes or restarts
  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    active_q && ovf_q && !start |=> ovf_q);
endmodule

// File: rtl/oc_fetch_ctrl.sv
module oc_fetch_ctrl
  import oc_pkg::*;
#(
  parameter int AW    = 20,
  parameter int SETS  = 16,
  parameter int WAYS  = 8,
  parameter int SLOTS = 8,
  parameter int OPW   = 16,
  localparam int IW   = $clog2(SETS),
  localparam int WB   = $clog2(WAYS),
  localparam int CW   = $clog2(SLOTS + 1),
  localparam int LW   = SLOTS * OPW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smt_en,
  input  logic                 fetch_valid,
  input  logic                 fetch_tid,
  input  logic [AW-1:0]        fetch_region,
  output logic                 fetch_ready,
  input  logic                 dec_valid,
  input  logic [2*OPW-1:0]     dec_op,
  input  logic                 dec_wide,
  input  logic                 dec_last,
  input  logic                 q_ready,
  output logic                 out_valid,
  output logic [LW-1:0]        out_slots,
  output logic [CW-1:0]        out_count,
  output logic                 oc_mode,
  output logic                 ic_clk_en,
  output logic                 ic_fetch_valid,
  output logic [AW-1:0]        ic_fetch_region
);
  logic [IW-1:0] lk_set;
  logic          lk_hit, lk_usable, hit_use, accept;
  logic [WB-1:0] lk_way, lk_victim;
  logic          cm_en, cm_usable;
  logic [AW-1:0] cm_tag;
  logic [IW-1:0] cm_set;
  logic [WB-1:0] cm_way;
  logic [LW-1:0] cm_line;
  logic [CW-1:0] cm_count;
  logic [CW+LW-1:0] rd_word;
  oc_mode_e      mode_q;

  // thread partition: the top index bit becomes the thread id
  assign lk_set = smt_en ? {fetch_tid, fetch_region[IW-2:0]} : fetch_region[IW-1:0];

  assign fetch_ready = !(out_valid && !q_ready);
  assign accept      = fetch_valid && fetch_ready;
  assign hit_use     = lk_hit && lk_usable;

  oc_tags #(.AW(AW), .SETS(SETS), .WAYS(WAYS)) i_tags (
    .clk(clk), .rst(rst),
    .lk_set(lk_set), .lk_tag(fetch_region),
    .lk_hit(lk_hit), .lk_usable(lk_usable), .lk_way(lk_way), .lk_victim(lk_victim),
    .wr_en(cm_en), .wr_set(cm_set), .wr_way(cm_way), .wr_tag(cm_tag), .wr_usable(cm_usable)
  );

  oc_fill #(.AW(AW), .SETS(SETS), .WAYS(WAYS), .SLOTS(SLOTS), .OPW(OPW)) i_fill (
    .clk(clk), .rst(rst),
    .start(accept && !lk_hit), .start_tag(fetch_region), .start_set(lk_set),
    .start_way(lk_victim),
    .dec_valid(dec_valid), .dec_op(dec_op), .dec_wide(dec_wide), .dec_last(dec_last),
    .cm_en(cm_en), .cm_tag(cm_tag), .cm_set(cm_set), .cm_way(cm_way),
    .cm_usable(cm_usable), .cm_line(cm_line), .cm_count(cm_count)
  );

  oc_line_ram #(.DW(CW + LW), .DEPTH(SETS * WAYS)) i_ram (
    .clk(clk),
    .we(cm_en), .waddr({cm_set, cm_way}), .wdata({cm_count, cm_line}),
    .re(accept), .raddr({lk_set, lk_way}), .rdata(rd_word)
  );

  assign out_slots = rd_word[LW-1:0];
  assign out_count = rd_word[CW+LW-1:LW];
  assign oc_mode   = mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid       <= 1'b0;
      mode_q          <= MODE_IC;
      ic_clk_en       <= 1'b1;
      ic_fetch_valid  <= 1'b0;
      ic_fetch_region <= '0;
    end else begin
      ic_fetch_valid <= accept && !hit_use;
      if (accept) begin
        out_valid <= hit_use;
        mode_q    <= hit_use ? MODE_OC : MODE_IC;
        ic_clk_en <= !hit_use;
        if (!hit_use) ic_fetch_region <= fetch_region;
      end else if (q_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R7: a stalled line is held unchanged
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    out_valid && !q_ready |=> out_valid && $stable(out_slots) && $stable(out_count));
  // R4: a delivered line means cache mode
  a_r4_oc_on_delivery: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> mode_q == MODE_OC);
  // R4: the decode front end is gated whenever cache mode runs
  a_r4_gate: assert property (@(posedge clk) disable iff (rst)
    mode_q == MODE_OC |-> !ic_clk_en);
  // R2: a decode-path request never coincides with a delivered line
  a_r2_ic_path: assert property (@(posedge clk) disable iff (rst)
    ic_fetch_valid |-> mode_q == MODE_IC && !out_valid);
  // R5: without a fetch the mode does not move
  a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid |=> $stable(mode_q));
endmodule

// File: tb/test_oc_fetch_ctrl.sv
module test_oc_fetch_ctrl;
  localparam int AW = 20, SLOTS = 8, OPW = 16, CW = 4, LW = SLOTS * OPW;

  logic clk = 1'b0, rst = 1'b1;
  logic smt_en = 1'b0, fetch_valid = 1'b0, fetch_tid = 1'b0;
  logic [AW-1:0] fetch_region = '0;
  logic fetch_ready;
  logic dec_valid = 1'b0, dec_wide = 1'b0, dec_last = 1'b0;
  logic [2*OPW-1:0] dec_op = '0;
  logic q_ready = 1'b1;
  logic out_valid, oc_mode, ic_clk_en, ic_fetch_valid;
  logic [LW-1:0] out_slots;
  logic [CW-1:0] out_count;
  logic [AW-1:0] ic_fetch_region;

  always #5 clk = ~clk;

  oc_fetch_ctrl i_oc_fetch_ctrl (
    .clk(clk), .rst(rst), .smt_en(smt_en), .fetch_valid(fetch_valid),
    .fetch_tid(fetch_tid), .fetch_region(fetch_region), .fetch_ready(fetch_ready),
    .dec_valid(dec_valid), .dec_op(dec_op), .dec_wide(dec_wide), .dec_last(dec_last),
    .q_ready(q_ready), .out_valid(out_valid), .out_slots(out_slots),
    .out_count(out_count), .oc_mode(oc_mode), .ic_clk_en(ic_clk_en),
    .ic_fetch_valid(ic_fetch_valid), .ic_fetch_region(ic_fetch_region)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;

  logic [LW-1:0] m_line [int];
  int            m_cnt  [int];
  logic [LW-1:0] q_line [$];
  int            q_cnt  [$];
  logic [AW-1:0] q_ic   [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: a line transfers at the next edge when out_valid && q_ready
  initial forever begin
    @(negedge clk); #1;
    if (!rst && out_valid && q_ready) begin
      if (q_cnt.size() == 0) chk(1'b0, "R4", "unexpected line", out_count, 0);
      else begin
        logic [LW-1:0] el, mask;
        int ec;
        el = q_line.pop_front();
        ec = q_cnt.pop_front();
        mask = '0;
        for (int k = 0; k < ec; k++) mask[k*OPW +: OPW] = '1;
        chk(out_count == CW'(ec), "R3", "slot count", out_count, ec);
        chk((out_slots & mask) == el, "R3", "slot contents", out_slots & mask, el);
      end
    end
    if (!rst && ic_fetch_valid) begin
      if (q_ic.size() == 0) chk(1'b0, "R2", "unexpected decode request", ic_fetch_region, 0);
      else begin
        logic [AW-1:0] ea;
        ea = q_ic.pop_front();
        chk(ic_fetch_region == ea, "R2", "decode request region", ic_fetch_region, ea);
      end
    end
  end

  task automatic do_fetch(input logic [AW-1:0] r, input logic tid);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_region = r; fetch_tid = tid;
    while (!fetch_ready) @(negedge clk);
    @(negedge clk);
    fetch_valid = 1'b0;
  endtask

  task automatic fetch_hit(input logic [AW-1:0] r, input logic tid, input string req);
    q_line.push_back(m_line[int'(r)]);
    q_cnt.push_back(m_cnt[int'(r)]);
    do_fetch(r, tid);
    chk(out_valid == 1'b1, req, "hit delivers", out_valid, 1);
    chk(oc_mode == 1'b1 && ic_clk_en == 1'b0, "R4", "cache mode, gate off",
        {oc_mode, ic_clk_en}, 2'b10);
  endtask

  task automatic fetch_ic(input logic [AW-1:0] r, input logic tid, input string req);
    q_ic.push_back(r);
    do_fetch(r, tid);
    chk(out_valid == 1'b0, req, "no line on decode path", out_valid, 0);
    chk(oc_mode == 1'b0 && ic_clk_en == 1'b1, "R2", "decode mode, gate on",
        {oc_mode, ic_clk_en}, 2'b01);
  endtask

  // feed n ops; bit i of wmask marks op i wide; expected packing per R3/R6
  task automatic fill(input logic [AW-1:0] r, input int n, input logic [15:0] wmask,
                      input logic [15:0] base);
    logic [LW-1:0] el = '0;
    int p = 0;
    bit ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      logic [OPW-1:0] lo, hi;
      lo = base + OPW'(i);
      hi = (base ^ 16'hA5A5) + OPW'(i);
      if (ok && p + (wmask[i] ? 2 : 1) <= SLOTS) begin
        el[p*OPW +: OPW] = lo;
        if (wmask[i]) el[(p+1)*OPW +: OPW] = hi;
        p += wmask[i] ? 2 : 1;
      end else ok = 1'b0;
      dec_valid = 1'b1; dec_op = {hi, lo}; dec_wide = wmask[i]; dec_last = (i == n - 1);
      @(negedge clk);
    end
    dec_valid = 1'b0; dec_last = 1'b0; dec_wide = 1'b0;
    @(negedge clk);
    if (ok) begin m_line[int'(r)] = el; m_cnt[int'(r)] = p; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
    chk(oc_mode == 1'b0, "R1", "oc_mode", oc_mode, 0);
    chk(ic_clk_en == 1'b1, "R1", "ic_clk_en", ic_clk_en, 1);
    chk(fetch_ready == 1'b1, "R1", "fetch_ready", fetch_ready, 1);

    // R2/R3/R4: miss, fill with a wide op, then hit
    fetch_ic(20'h00010, 1'b0, "R2");
    fill(20'h00010, 5, 16'b01000, 16'h1000);
    fetch_hit(20'h00010, 1'b0, "R4");
    // R5: consecutive hit and idle cycles keep cache mode
    fetch_hit(20'h00010, 1'b0, "R5");
    repeat (4) @(negedge clk);
    chk(oc_mode == 1'b1, "R5", "mode after idle", oc_mode, 1);

    // R6: exactly full line is usable
    fetch_ic(20'h00011, 1'b0, "R2");
    chk(oc_mode == 1'b0, "R5", "miss leaves cache mode", oc_mode, 0);
    fill(20'h00011, 4, 16'b1111, 16'h2000);
    fetch_hit(20'h00011, 1'b0, "R6");
    // R6: overflow gives unusable line, served by decode path from cache mode
    fetch_ic(20'h00012, 1'b0, "R2");
    fill(20'h00012, 6, 16'b111000, 16'h3000);
    fetch_hit(20'h00010, 1'b0, "R5");
    fetch_ic(20'h00012, 1'b0, "R6");
    fetch_ic(20'h00012, 1'b0, "R6");
    repeat (3) @(negedge clk);
    chk(oc_mode == 1'b0, "R5", "decode mode held while idle", oc_mode, 0);

    // R7: stall holds the line and blocks fetches
    q_ready = 1'b0;
    fetch_hit(20'h00010, 1'b0, "R7");
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); #1;
      chk(fetch_ready == 1'b0, "R7", "fetch_ready while stalled", fetch_ready, 0);
      chk(out_valid == 1'b1 && out_count == CW'(m_cnt[32'h10]), "R7", "held line",
          out_count, m_cnt[32'h10]);
    end
    @(negedge clk);
    q_ready = 1'b1;
    fetch_hit(20'h00011, 1'b0, "R7");

    // R8: nine regions in set 3
    for (int k = 1; k <= 9; k++) begin
      fetch_ic(AW'(k * 16 + 3), 1'b0, "R8");
      fill(AW'(k * 16 + 3), 1, 16'b0, 16'(16'h4000 + k * 16));
    end
    fetch_ic(AW'(19), 1'b0, "R8");
    for (int k = 2; k <= 9; k++) fetch_hit(AW'(k * 16 + 3), 1'b0, "R8");

    // R9: partitioned sets under two threads
    smt_en = 1'b1;
    fetch_ic(20'h00125, 1'b0, "R9");
    fill(20'h00125, 3, 16'b010, 16'h5000);
    fetch_hit(20'h00125, 1'b0, "R9");
    fetch_ic(20'h00125, 1'b1, "R9");
    smt_en = 1'b0;
    fetch_ic(20'h00047, 1'b1, "R9");
    fill(20'h00047, 2, 16'b00, 16'h6000);
    fetch_hit(20'h00047, 1'b0, "R9");

    repeat (4) @(negedge clk);
    chk(q_line.size() == 0 && q_ic.size() == 0, "R4", "scoreboard drained",
        q_line.size() + q_ic.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule